// File: doc/BRIEF.md
# Raster Timing Generator with Output Priority

This block produces the horizontal and vertical beam timing for a programmable video controller and classifies every pixel position into one of four output kinds: sync, blank, display or border. Software programs a small bank of timing points for each axis through a single-cycle write port. For each axis these are the last count of the line or frame, the last sync position, the window edges of the visible (non-blanked) area and the window edges of the active picture. A pixel-clock enable paces the counters. The horizontal counter moves once every two enabled pixels, so horizontal points are expressed in two-pixel units.

Each axis keeps a position counter and a set of sticky flags. A flag is set when the counter leaves the matching timing point, and all flags of an axis clear when that axis wraps to zero. The four output kinds are combined by a fixed precedence: sync first, then blank, then display, with border filling whatever is left. A separate flag reports when both axes are inside their active-picture windows. The colour-depth selection and the horizontal visible-window edges are double-buffered. Each is taken up at a fixed point in the frame, so a mid-frame write cannot tear the current picture. All other timing points act at the next comparison.

Top module: `raster_timing_gen`

## Requirements
- R1: The horizontal position advances by one on every second cycle in which `pix_en` is high, counted from reset. When `pix_en` is low, both positions and the output class hold their values.
- R2: A total register holding M-1 gives M positions, 0 to M-1. When the horizontal position wraps from its total to 0, the vertical position advances by one. The vertical position wraps to 0 after its own total.
- R3: A position is in sync when either axis's position is at or below that axis's sync-end value.
- R4: A position is blanked unless, on both axes, its position P satisfies start < P <= end for that axis's visible-window points.
- R5: `disp_active` is 1 exactly when, on both axes, start < P <= end holds for the active-picture points.
- R6: `out_class` is encoded as 2'b11 sync, 2'b10 blank, 2'b01 display and 2'b00 border, with that order of precedence. Display is reported only when `disp_active` is 1 and the position is neither sync nor blank.
- R7: Region flags restart on every wrap, so every line and every frame repeats the same pattern.
- R8: A write to a total, sync-end, vertical visible-window or active-picture register is used at the very next counter comparison.
- R9: Writes to the horizontal visible-window edges (addresses 4'h2 and 4'h3) are held in a shadow. The shadow is copied into use when the horizontal counter wraps on the line whose vertical position equals the vertical active-picture end value.
- R10: The colour depth written at address 4'hF (low bits of `wr_data`) appears on `depth_q` only after the vertical position next wraps to 0.
- R11: Register map: 4'h0 h total, 4'h1 h sync end, 4'h2 h visible start, 4'h3 h visible end, 4'h4 h picture start, 4'h5 h picture end, 4'h8 v total, 4'h9 v sync end, 4'hA v visible start, 4'hB v visible end, 4'hC v picture start, 4'hD v picture end, 4'hF depth. Writes to any other address change nothing.
- R12: After reset, every register and both positions are zero, `out_class` is sync, `disp_active` is 0 and `depth_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel-clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | CW | Register write data |
| out_class | output | 2 | Pixel output class |
| disp_active | output | 1 | Both axes inside the active-picture window |
| depth_q | output | DW | Colour depth in use for this frame |
| hpos | output | CW | Horizontal position, in two-pixel units |
| vpos | output | CW | Vertical position, in lines |

## Verification
The bench drives the first frame after programming. In that frame the horizontal visible window is still the reset value, so rows above the latch line must read blank even though `disp_active` is high. A design that applied the shadow at once, or that let display outrank blank, would show picture there. A mid-frame write to the picture end must cut the very next line short. In the same frame, new visible-window edges and a new depth must stay unused until the latch line and the frame wrap; a design that skipped the shadow would move the borders or the depth early. Enable pauses, writes to unmapped addresses, and a full reference model compared on every cycle also expose off-by-one window edges, flags that survive a wrap, and a counter that steps on every pixel instead of every second one.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  typedef enum logic [1:0] {
    CL_BORDER  = 2'b00,
    CL_DISPLAY = 2'b01,
    CL_BLANK   = 2'b10,
    CL_SYNC    = 2'b11
  } pix_class_e;

  localparam int unsigned AW = 4;

  localparam logic [AW-1:0] A_H_TOTAL = 4'h0;
  localparam logic [AW-1:0] A_H_SYNC  = 4'h1;
  localparam logic [AW-1:0] A_H_VIS_S = 4'h2;
  localparam logic [AW-1:0] A_H_VIS_E = 4'h3;
  localparam logic [AW-1:0] A_H_PIC_S = 4'h4;
  localparam logic [AW-1:0] A_H_PIC_E = 4'h5;
  localparam logic [AW-1:0] A_V_TOTAL = 4'h8;
  localparam logic [AW-1:0] A_V_SYNC  = 4'h9;
  localparam logic [AW-1:0] A_V_VIS_S = 4'hA;
  localparam logic [AW-1:0] A_V_VIS_E = 4'hB;
  localparam logic [AW-1:0] A_V_PIC_S = 4'hC;
  localparam logic [AW-1:0] A_V_PIC_E = 4'hD;
  localparam logic [AW-1:0] A_DEPTH   = 4'hF;

  // a region is live once its opening point has passed and its closing point has not
  function automatic logic in_window(input logic opened, input logic closed);
    return opened & ~closed;
  endfunction

  // fixed precedence: sync, blank, display, then border
  function automatic pix_class_e pick_class(input logic any_sync,
                                            input logic any_blank,
                                            input logic both_pic);
    if (any_sync)       return CL_SYNC;
    else if (any_blank) return CL_BLANK;
    else if (both_pic)  return CL_DISPLAY;
    else                return CL_BORDER;
  endfunction

endpackage

// File: rtl/rtg_regfile.sv
module rtg_regfile
  import rtg_pkg::*;
#(
  parameter int CW = 10,
  parameter int DW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          vint,
  input  logic          vwrap,
  output logic [CW-1:0] h_tot,
  output logic [CW-1:0] h_se,
  output logic [CW-1:0] h_vs,
  output logic [CW-1:0] h_ve,
  output logic [CW-1:0] h_ps,
  output logic [CW-1:0] h_pe,
  output logic [CW-1:0] v_tot,
  output logic [CW-1:0] v_se,
  output logic [CW-1:0] v_vs,
  output logic [CW-1:0] v_ve,
  output logic [CW-1:0] v_ps,
  output logic [CW-1:0] v_pe,
  output logic [DW-1:0] depth
);

  logic [CW-1:0] h_vs_sh, h_ve_sh;
  logic [DW-1:0] depth_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_tot <= '0; h_se <= '0; h_ps <= '0; h_pe <= '0;
      v_tot <= '0; v_se <= '0; v_vs <= '0; v_ve <= '0;
      v_ps  <= '0; v_pe <= '0;
      h_vs_sh <= '0; h_ve_sh <= '0; depth_sh <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_H_TOTAL: h_tot    <= wr_data;
        A_H_SYNC:  h_se     <= wr_data;
        A_H_VIS_S: h_vs_sh  <= wr_data;
        A_H_VIS_E: h_ve_sh  <= wr_data;
        A_H_PIC_S: h_ps     <= wr_data;
        A_H_PIC_E: h_pe     <= wr_data;
        A_V_TOTAL: v_tot    <= wr_data;
        A_V_SYNC:  v_se     <= wr_data;
        A_V_VIS_S: v_vs     <= wr_data;
        A_V_VIS_E: v_ve     <= wr_data;
        A_V_PIC_S: v_ps     <= wr_data;
        A_V_PIC_E: v_pe     <= wr_data;
        A_DEPTH:   depth_sh <= wr_data[DW-1:0];
        default: ;
      endcase
    end
  end

  // horizontal visible edges move into use at the vertical interrupt point
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_vs <= '0;
      h_ve <= '0;
    end else if (vint) begin
      h_vs <= h_vs_sh;
      h_ve <= h_ve_sh;
    end
  end

  // colour depth is fixed for a whole frame
  always_ff @(posedge clk) begin
    if (!rst_n)     depth <= '0;
    else if (vwrap) depth <= depth_sh;
  end

endmodule

// File: rtl/rtg_axis.sv
module rtg_axis
  import rtg_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [CW-1:0] total,
  input  logic [CW-1:0] sync_end,
  input  logic [CW-1:0] vis_start,
  input  logic [CW-1:0] vis_end,
  input  logic [CW-1:0] pic_start,
  input  logic [CW-1:0] pic_end,
  output logic [CW-1:0] pos,
  output logic          wrap,
  output logic          sync_on,
  output logic          blank_on,
  output logic          pic_on
);

  localparam int NPT = 5;
  localparam int P_SYNC = 0, P_VS = 1, P_VE = 2, P_PS = 3, P_PE = 4;

  logic [CW-1:0]  pts [NPT];
  logic [NPT-1:0] passed;

  assign pts[P_SYNC] = sync_end;
  assign pts[P_VS]   = vis_start;
  assign pts[P_VE]   = vis_end;
  assign pts[P_PS]   = pic_start;
  assign pts[P_PE]   = pic_end;

  assign wrap = step && (pos == total);

  always_ff @(posedge clk) begin
    if (!rst_n)    pos <= '0;
    else if (wrap) pos <= '0;
    else if (step) pos <= pos + 1'b1;
  end

  // one sticky flag per timing point, compared just before the counter moves
  for (genvar g = 0; g < NPT; g++) begin : g_pt
    logic hit_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                       hit_q <= 1'b0;
      else if (wrap)                    hit_q <= 1'b0;
      else if (step && pos == pts[g])   hit_q <= 1'b1;
    end
    assign passed[g] = hit_q;
  end

  assign sync_on  = ~passed[P_SYNC];
  assign blank_on = ~in_window(passed[P_VS], passed[P_VE]);
  assign pic_on   =  in_window(passed[P_PS], passed[P_PE]);

endmodule

// File: rtl/rtg_classify.sv
module rtg_classify
  import rtg_pkg::*;
(
  input  logic       h_sync,
  input  logic       h_blank,
  input  logic       h_pic,
  input  logic       v_sync,
  input  logic       v_blank,
  input  logic       v_pic,
  output logic [1:0] cls,
  output logic       both_pic
);

  pix_class_e c;

  assign both_pic = h_pic & v_pic;
  assign c        = pick_class(h_sync | v_sync, h_blank | v_blank, both_pic);
  assign cls      = c;

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int CW = 10,
  parameter int DW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [1:0]    out_class,
  output logic          disp_active,
  output logic [DW-1:0] depth_q,
  output logic [CW-1:0] hpos,
  output logic [CW-1:0] vpos
);

  logic          half_q;
  logic          h_step, h_wrap, v_wrap, vint;
  logic [CW-1:0] h_tot, h_se, h_vs, h_ve, h_ps, h_pe;
  logic [CW-1:0] v_tot, v_se, v_vs, v_ve, v_ps, v_pe;
  logic          h_sync, h_blank, h_pic, v_sync, v_blank, v_pic;

  // horizontal units are two pixels wide
  always_ff @(posedge clk) begin
    if (!rst_n)      half_q <= 1'b0;
    else if (pix_en) half_q <= ~half_q;
  end

  assign h_step = pix_en & half_q;
  assign vint   = h_wrap && (vpos == v_pe);

  rtg_regfile #(.CW(CW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vint(vint), .vwrap(v_wrap),
    .h_tot(h_tot), .h_se(h_se), .h_vs(h_vs), .h_ve(h_ve), .h_ps(h_ps), .h_pe(h_pe),
    .v_tot(v_tot), .v_se(v_se), .v_vs(v_vs), .v_ve(v_ve), .v_ps(v_ps), .v_pe(v_pe),
    .depth(depth_q)
  );

  rtg_axis #(.CW(CW)) u_h (
    .clk(clk), .rst_n(rst_n), .step(h_step),
    .total(h_tot), .sync_end(h_se), .vis_start(h_vs), .vis_end(h_ve),
    .pic_start(h_ps), .pic_end(h_pe),
    .pos(hpos), .wrap(h_wrap), .sync_on(h_sync), .blank_on(h_blank), .pic_on(h_pic)
  );

  rtg_axis #(.CW(CW)) u_v (
    .clk(clk), .rst_n(rst_n), .step(h_wrap),
    .total(v_tot), .sync_end(v_se), .vis_start(v_vs), .vis_end(v_ve),
    .pic_start(v_ps), .pic_end(v_pe),
    .pos(vpos), .wrap(v_wrap), .sync_on(v_sync), .blank_on(v_blank), .pic_on(v_pic)
  );

  rtg_classify u_cls (
    .h_sync(h_sync), .h_blank(h_blank), .h_pic(h_pic),
    .v_sync(v_sync), .v_blank(v_blank), .v_pic(v_pic),
    .cls(out_class), .both_pic(disp_active)
  );

endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
  parameter int CW = 10,
  parameter int DW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_en,
  input logic          h_wrap,
  input logic          v_wrap,
  input logic          vint,
  input logic [CW-1:0] hpos,
  input logic [CW-1:0] vpos,
  input logic [1:0]    out_class,
  input logic          disp_active,
  input logic [DW-1:0] depth_q,
  input logic [CW-1:0] hb_s,
  input logic [CW-1:0] hb_e
);

  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(hpos) && $stable(vpos) && $stable(out_class))); // R1

  AST_H_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    h_wrap |=> (hpos == '0)); // R2

  AST_V_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wrap && !v_wrap) |=> (vpos == CW'($past(vpos) + 1'b1))); // R2

  AST_SYNC_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    (hpos == '0) |-> (out_class == 2'b11)); // R3

  AST_DISP_NEEDS_PIC: assert property (@(posedge clk) disable iff (!rst_n)
    (out_class == 2'b01) |-> disp_active); // R6

  AST_HB_ONLY_AT_VINT: assert property (@(posedge clk) disable iff (!rst_n)
    !vint |=> ($stable(hb_s) && $stable(hb_e))); // R9

  AST_DEPTH_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !v_wrap |=> $stable(depth_q)); // R10

endmodule

bind raster_timing_gen rtg_checker #(.CW(CW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .h_wrap(h_wrap), .v_wrap(v_wrap),
  .vint(vint), .hpos(hpos), .vpos(vpos), .out_class(out_class),
  .disp_active(disp_active), .depth_q(depth_q), .hb_s(h_vs), .hb_e(h_ve)
);

// File: tb/raster_timing_gen_tb_top.sv
`timescale 1ns/1ps
module raster_timing_gen_tb_top;
  localparam int CW = 10;
  localparam int DW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pix_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [1:0]    out_class;
  logic          disp_active;
  logic [DW-1:0] depth_q;
  logic [CW-1:0] hpos, vpos;

  int tests = 0, fails = 0, cyc_cnt = 0;

  // bench-side view of the programmed timing
  int m_htot, m_hse, m_hps, m_hpe, m_hvs, m_hve, m_hvs_sh, m_hve_sh;
  int m_vtot, m_vse, m_vvs, m_vve, m_vps, m_vpe;
  int m_depth, m_depth_sh;
  int m_h, m_v, m_half;

  raster_timing_gen #(.CW(CW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .out_class(out_class), .disp_active(disp_active),
    .depth_q(depth_q), .hpos(hpos), .vpos(vpos)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 100000", cyc_cnt);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (h=%0d v=%0d)", req, act, exp, m_h, m_v);
    end
  endtask

  function automatic int exp_class(input int h, input int v);
    bit sync, vis, pic;
    sync = (h <= m_hse) || (v <= m_vse);
    vis  = (h > m_hvs && h <= m_hve) && (v > m_vvs && v <= m_vve);
    pic  = (h > m_hps && h <= m_hpe) && (v > m_vps && v <= m_vpe);
    if (sync)     return 3;
    else if (!vis) return 2;
    else if (pic)  return 1;
    else           return 0;
  endfunction

  function automatic int exp_pic(input int h, input int v);
    return ((h > m_hps && h <= m_hpe) && (v > m_vps && v <= m_vpe)) ? 1 : 0;
  endfunction

  // one enabled pixel in the reference view
  task automatic model_pixel();
    if (m_half == 1) begin
      if (m_h == m_htot) begin
        m_h = 0;
        if (m_v == m_vpe) begin m_hvs = m_hvs_sh; m_hve = m_hve_sh; end
        if (m_v == m_vtot) begin m_v = 0; m_depth = m_depth_sh; end
        else m_v = m_v + 1;
      end else m_h = m_h + 1;
    end
    m_half = 1 - m_half;
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " R1 R2 hpos"}, int'(hpos), m_h);
    chk({tag, " R2 vpos"}, int'(vpos), m_v);
    chk({tag, " R3 R4 R6 class"}, int'(out_class), exp_class(m_h, m_v));
    chk({tag, " R5 disp_active"}, int'(disp_active), exp_pic(m_h, m_v));
    chk({tag, " R10 depth"}, int'(depth_q), m_depth);
  endtask

  // one clock: inputs were set after the previous negedge, sample at the next
  task automatic cycle(input string tag);
    bit pe;
    pe = pix_en;
    @(negedge clk);
    if (pe) model_pixel();
    compare_all(tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(tag);
  endtask

  task automatic wr(input logic [3:0] a, input int d, input string tag);
    wr_en = 1'b1; wr_addr = a; wr_data = CW'(d);
    cycle(tag);
    wr_en = 1'b0;
    case (a)
      4'h0: m_htot = d;    4'h1: m_hse = d;     4'h2: m_hvs_sh = d;
      4'h3: m_hve_sh = d;  4'h4: m_hps = d;     4'h5: m_hpe = d;
      4'h8: m_vtot = d;    4'h9: m_vse = d;     4'hA: m_vvs = d;
      4'hB: m_vve = d;     4'hC: m_vps = d;     4'hD: m_vpe = d;
      4'hF: m_depth_sh = d % (1 << DW);
      default: ;
    endcase
  endtask

  task automatic t_reset();
    m_htot = 0; m_hse = 0; m_hps = 0; m_hpe = 0; m_hvs = 0; m_hve = 0;
    m_hvs_sh = 0; m_hve_sh = 0; m_vtot = 0; m_vse = 0; m_vvs = 0; m_vve = 0;
    m_vps = 0; m_vpe = 0; m_depth = 0; m_depth_sh = 0; m_h = 0; m_v = 0; m_half = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset class", int'(out_class), 3);
    chk("R12 reset disp_active", int'(disp_active), 0);
    chk("R12 reset depth", int'(depth_q), 0);
    chk("R12 reset hpos", int'(hpos), 0);
    chk("R12 reset vpos", int'(vpos), 0);
  endtask

  // program a 10 x 8 raster while the enable is low: nothing may move (R1)
  task automatic t_program_idle();
    wr(4'h0, 9, "R11 prog"); wr(4'h1, 1, "R11 prog");
    wr(4'h2, 2, "R11 prog"); wr(4'h3, 8, "R11 prog");
    wr(4'h4, 3, "R11 prog"); wr(4'h5, 7, "R11 prog");
    wr(4'h8, 7, "R11 prog"); wr(4'h9, 0, "R11 prog");
    wr(4'hA, 1, "R11 prog"); wr(4'hB, 6, "R11 prog");
    wr(4'hC, 2, "R11 prog"); wr(4'hD, 5, "R11 prog");
    wr(4'hF, 1, "R10 prog");
    run(5, "R1 idle");
    chk("R1 idle hold class", int'(out_class), 3);
  endtask

  // first frames: reset-valued horizontal window until the latch line (R9)
  task automatic t_frames();
    bit saw_pic_under_blank;
    saw_pic_under_blank = 0;
    pix_en = 1'b1;
    for (int i = 0; i < 320; i++) begin
      cycle("R7 R9 frames");
      if (disp_active && out_class == 2'b10) saw_pic_under_blank = 1;
    end
    chk("R6 R9 blank outranks display in first frame", int'(saw_pic_under_blank), 1);
    chk("R10 depth after first wrap", int'(depth_q), 1);
  endtask

  task automatic t_pause();
    int h0, c0;
    while (!(m_h == 5 && m_v == 4)) cycle("R1 seek");
    h0 = int'(hpos); c0 = int'(out_class);
    pix_en = 1'b0;
    run(7, "R1 pause");
    chk("R1 hpos held during pause", int'(hpos), h0);
    chk("R1 class held during pause", int'(out_class), c0);
    pix_en = 1'b1;
    run(40, "R1 resume");
  endtask

  // live writes at the start of a frame
  task automatic t_live_write();
    while (!(m_h == 0 && m_v == 0 && m_half == 0)) cycle("R8 seek");
    wr(4'h5, 5, "R8 live");
    wr(4'h2, 4, "R9 live");
    wr(4'h3, 6, "R9 live");
    wr(4'hF, 2, "R10 live");
    // picture end must already be short on line 0 of... line 3
    while (!(m_v == 3 && m_h == 6)) cycle("R8 run");
    chk("R8 picture end applied immediately", int'(disp_active), 0);
    chk("R10 depth held mid-frame", int'(depth_q), 1);
    while (!(m_v == 6 && m_h == 7)) cycle("R9 run");
    chk("R9 new visible end applied after latch line", int'(out_class), 2);
    run(200, "R9 R10 next");
    chk("R10 depth after wrap", int'(depth_q), 2);
  endtask

  task automatic t_unused();
    wr(4'h6, 1, "R11 unused");
    wr(4'h7, 3, "R11 unused");
    wr(4'hE, 2, "R11 unused");
    run(170, "R11 after unused");
    chk("R11 depth untouched", int'(depth_q), 2);
  endtask

  initial begin
    t_reset();
    t_program_idle();
    t_frames();
    t_pause();
    t_live_write();
    t_unused();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule